// File: doc/BRIEF.md
# Output and Input Shift Staging

This block holds the two word-wide staging registers that sit between a programmable I/O sequencer's bit-level datapath and its word-level queues. On the output side, a pull command copies one full word from the transmit queue into the output shift register. Out commands then peel off a chosen number of bits at a time toward pins or a scratch register. On the input side, in commands feed a chosen number of source bits into the input shift register. A push command hands the collected word to the receive queue.

Each side keeps a counter. The output counter tracks how many bits have been consumed since the last pull. The input counter tracks how many bits have been collected since the last push. Each register has its own direction setting that picks either LSB-first or MSB-first shifting. When a queue transfer cannot complete at once, it stalls and raises a busy flag until the queue is ready.

Top module: `io_shift_stage`

## Requirements
- R1: While rst_ni is low, both counters read 0, both busy flags are low and out_valid_o is low. With no commands present, txq_ready_o and rxq_valid_o are low.
- R2: When a pull is requested (pull_i high, or a pull still pending) and txq_valid_i is high, txq_ready_o is high in that same cycle. At the next edge, txq_data_i is loaded into the output register and osr_cnt_o becomes 0.
- R3: A pull requested while txq_valid_i is low raises pull_busy_o at the next edge. The flag stays high until a cycle in which txq_valid_i is high; the word is taken in that cycle and pull_busy_o drops at the following edge.
- R4: A shift-count select of 0 means a full word of 32 bits. Any value 1..31 means that many bits.
- R5: With osr_dir_i=1 (right), an accepted out emits the register's low n bits right-aligned on out_bits_o (upper bits zero), with out_valid_o high for one cycle after the command. The register then shifts right by n, and zeros fill from the top.
- R6: With osr_dir_i=0 (left), an accepted out emits the register's high n bits right-aligned on out_bits_o. The register then shifts left by n, and zeros fill from the bottom.
- R7: Each accepted out adds n to osr_cnt_o. The counter saturates at 32.
- R8: With isr_dir_i=1 (right), an accepted in shifts the register right by n. The low n bits of in_data_i enter at the top.
- R9: With isr_dir_i=0 (left), an accepted in shifts the register left by n. The low n bits of in_data_i enter at the bottom.
- R10: Each accepted in adds n to isr_cnt_o. The counter saturates at 32.
- R11: While a push is requested (push_i high, or a push still pending), rxq_valid_o is high and rxq_data_o shows the input register. A cycle with rxq_ready_i high transfers the word, and at the next edge both the input register and isr_cnt_o are cleared.
- R12: A push requested while rxq_ready_i is low raises push_busy_o at the next edge. The flag stays high until the transfer completes.
- R13: An out in a cycle with a pull requested or pending has no effect: out_valid_o stays low and the register and counter are unchanged. Likewise, an in in a cycle with a push requested or pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osr_dir_i | input | 1 | Output register direction, 1 = right |
| isr_dir_i | input | 1 | Input register direction, 1 = right |
| pull_i | input | 1 | Pull command strobe |
| txq_data_i | input | 32 | Transmit queue head word |
| txq_valid_i | input | 1 | Transmit queue not empty |
| txq_ready_o | output | 1 | Pop the transmit queue this cycle |
| pull_busy_o | output | 1 | Pull stalled on empty queue |
| out_i | input | 1 | Out command strobe |
| out_sel_i | input | 5 | Out bit count, 0 = 32 |
| out_bits_o | output | 32 | Bits shifted out, right-aligned |
| out_valid_o | output | 1 | out_bits_o holds a new result |
| osr_cnt_o | output | 6 | Bits consumed since last pull |
| in_i | input | 1 | In command strobe |
| in_sel_i | input | 5 | In bit count, 0 = 32 |
| in_data_i | input | 32 | Source bits, low bits used |
| isr_cnt_o | output | 6 | Bits collected since last push |
| push_i | input | 1 | Push command strobe |
| rxq_data_o | output | 32 | Word offered to the receive queue |
| rxq_valid_o | output | 1 | Push requested |
| rxq_ready_i | input | 1 | Receive queue has space |
| push_busy_o | output | 1 | Push stalled on full queue |

## Verification
The bench builds the block with its default word width of 32, so the count width is 6 and the select width is 5. At this width the zero select stands for a full 32-bit shift. That brings within reach the edge case where a shift amount equals the register width, and also counter saturation after a few shifts. The random mix overlaps commands with stalls, which exercises the rule that ignores an out or in while a pull or push is pending.

// File: rtl/io_shift_pkg.sv
package io_shift_pkg;
  typedef enum logic {
    SHIFT_LEFT  = 1'b0,
    SHIFT_RIGHT = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/io_shift_count.sv
// Decodes a count select (0 = full word) and forms the saturating counter sum.
module io_shift_count #(
  parameter int DATA_W = 32,
  localparam int SEL_W = $clog2(DATA_W),
  localparam int CNT_W = SEL_W + 1
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] n_o,
  output logic [CNT_W-1:0] sum_o
);
  localparam logic [CNT_W:0] FULL = (CNT_W+1)'(DATA_W);
  logic [CNT_W:0] sum_w;

  assign n_o   = (sel_i == '0) ? CNT_W'(DATA_W) : {1'b0, sel_i};
  assign sum_w = {1'b0, cnt_i} + {1'b0, n_o};
  assign sum_o = (sum_w > FULL) ? CNT_W'(DATA_W) : sum_w[CNT_W-1:0];
endmodule

// File: rtl/io_osr.sv
module io_osr
  import io_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SEL_W = $clog2(DATA_W),
  localparam int CNT_W = SEL_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_i,
  input  logic              pull_i,
  input  logic [DATA_W-1:0] txq_data_i,
  input  logic              txq_valid_i,
  output logic              txq_ready_o,
  output logic              pull_busy_o,
  input  logic              out_i,
  input  logic [SEL_W-1:0]  out_sel_i,
  output logic [DATA_W-1:0] out_bits_o,
  output logic              out_valid_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] W_C = CNT_W'(DATA_W);

  logic [DATA_W-1:0] osr_q, bits_q, bits_d, shift_d;
  logic [CNT_W-1:0]  cnt_q, n, cnt_sum;
  logic              pend_q, valid_q, req, pop, acc;
  shift_dir_e        dir;

  assign dir = shift_dir_e'(dir_i);
  assign req = pull_i | pend_q;
  assign pop = req & txq_valid_i;
  assign acc = out_i & ~req;   // pull has priority over out

  io_shift_count #(.DATA_W(DATA_W)) u_cnt (
    .sel_i(out_sel_i), .cnt_i(cnt_q), .n_o(n), .sum_o(cnt_sum)
  );

  always_comb begin
    if (dir == SHIFT_RIGHT) begin
      bits_d  = osr_q & ({DATA_W{1'b1}} >> (W_C - n));
      shift_d = osr_q >> n;
    end else begin
      bits_d  = osr_q >> (W_C - n);
      shift_d = osr_q << n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osr_q   <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
      bits_q  <= '0;
    end else begin
      pend_q  <= req & ~txq_valid_i;
      valid_q <= acc;
      if (acc) bits_q <= bits_d;
      if (pop) begin
        osr_q <= txq_data_i;
        cnt_q <= '0;
      end else if (acc) begin
        osr_q <= shift_d;
        cnt_q <= cnt_sum;
      end
    end
  end

  assign txq_ready_o = pop;
  assign pull_busy_o = pend_q;
  assign out_bits_o  = bits_q;
  assign out_valid_o = valid_q;
  assign cnt_o       = cnt_q;

  AST_OSR_CNT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= W_C); // R7
  AST_PULL_CLEARS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txq_ready_o |=> (cnt_o == '0)); // R2
  AST_PULL_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_busy_o && !txq_valid_i) |=> pull_busy_o); // R3
  AST_OUT_NOT_DURING_PULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ($past(out_i) && !$past(pull_i))); // R13
endmodule

// File: rtl/io_isr.sv
module io_isr
  import io_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SEL_W = $clog2(DATA_W),
  localparam int CNT_W = SEL_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_i,
  input  logic              in_i,
  input  logic [SEL_W-1:0]  in_sel_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic [CNT_W-1:0]  cnt_o,
  input  logic              push_i,
  output logic [DATA_W-1:0] rxq_data_o,
  output logic              rxq_valid_o,
  input  logic              rxq_ready_i,
  output logic              push_busy_o
);
  localparam logic [CNT_W-1:0] W_C = CNT_W'(DATA_W);

  logic [DATA_W-1:0] isr_q, bits, shift_d;
  logic [CNT_W-1:0]  cnt_q, n, cnt_sum;
  logic              pend_q, req, xfer, acc;
  shift_dir_e        dir;

  assign dir  = shift_dir_e'(dir_i);
  assign req  = push_i | pend_q;
  assign xfer = req & rxq_ready_i;
  assign acc  = in_i & ~req;   // push has priority over in

  io_shift_count #(.DATA_W(DATA_W)) u_cnt (
    .sel_i(in_sel_i), .cnt_i(cnt_q), .n_o(n), .sum_o(cnt_sum)
  );

  assign bits = in_data_i & ({DATA_W{1'b1}} >> (W_C - n));

  always_comb begin
    if (dir == SHIFT_RIGHT) shift_d = (isr_q >> n) | (bits << (W_C - n));
    else                    shift_d = (isr_q << n) | bits;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q  <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= req & ~rxq_ready_i;
      if (xfer) begin
        isr_q <= '0;
        cnt_q <= '0;
      end else if (acc) begin
        isr_q <= shift_d;
        cnt_q <= cnt_sum;
      end
    end
  end

  assign rxq_data_o  = isr_q;
  assign rxq_valid_o = req;
  assign push_busy_o = pend_q;
  assign cnt_o       = cnt_q;

  AST_ISR_CNT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= W_C); // R10
  AST_PUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxq_valid_o && rxq_ready_i) |=> (cnt_o == '0 && rxq_data_o == '0)); // R11
  AST_PUSH_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_busy_o && !rxq_ready_i) |=> push_busy_o); // R12
  AST_IN_NOT_DURING_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxq_valid_o && !rxq_ready_i) |=> ($stable(cnt_o) && $stable(rxq_data_o))); // R13
endmodule

// File: rtl/io_shift_stage.sv
module io_shift_stage #(
  parameter int DATA_W = 32,
  localparam int SEL_W = $clog2(DATA_W),
  localparam int CNT_W = SEL_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osr_dir_i,
  input  logic              isr_dir_i,
  input  logic              pull_i,
  input  logic [DATA_W-1:0] txq_data_i,
  input  logic              txq_valid_i,
  output logic              txq_ready_o,
  output logic              pull_busy_o,
  input  logic              out_i,
  input  logic [SEL_W-1:0]  out_sel_i,
  output logic [DATA_W-1:0] out_bits_o,
  output logic              out_valid_o,
  output logic [CNT_W-1:0]  osr_cnt_o,
  input  logic              in_i,
  input  logic [SEL_W-1:0]  in_sel_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic [CNT_W-1:0]  isr_cnt_o,
  input  logic              push_i,
  output logic [DATA_W-1:0] rxq_data_o,
  output logic              rxq_valid_o,
  input  logic              rxq_ready_i,
  output logic              push_busy_o
);
  io_osr #(.DATA_W(DATA_W)) u_osr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dir_i       (osr_dir_i),
    .pull_i      (pull_i),
    .txq_data_i  (txq_data_i),
    .txq_valid_i (txq_valid_i),
    .txq_ready_o (txq_ready_o),
    .pull_busy_o (pull_busy_o),
    .out_i       (out_i),
    .out_sel_i   (out_sel_i),
    .out_bits_o  (out_bits_o),
    .out_valid_o (out_valid_o),
    .cnt_o       (osr_cnt_o)
  );

  io_isr #(.DATA_W(DATA_W)) u_isr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dir_i       (isr_dir_i),
    .in_i        (in_i),
    .in_sel_i    (in_sel_i),
    .in_data_i   (in_data_i),
    .cnt_o       (isr_cnt_o),
    .push_i      (push_i),
    .rxq_data_o  (rxq_data_o),
    .rxq_valid_o (rxq_valid_o),
    .rxq_ready_i (rxq_ready_i),
    .push_busy_o (push_busy_o)
  );
endmodule

// File: tb/io_shift_stage_bench.sv
`timescale 1ns/1ps
module io_shift_stage_bench;
  localparam int W = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic osr_dir_i = 1'b0, isr_dir_i = 1'b0;
  logic pull_i = 1'b0, txq_valid_i = 1'b0, out_i = 1'b0, in_i = 1'b0;
  logic push_i = 1'b0, rxq_ready_i = 1'b0;
  logic [W-1:0] txq_data_i = '0, in_data_i = '0;
  logic [4:0] out_sel_i = '0, in_sel_i = '0;
  logic txq_ready_o, pull_busy_o, out_valid_o, rxq_valid_o, push_busy_o;
  logic [W-1:0] out_bits_o, rxq_data_o;
  logic [5:0] osr_cnt_o, isr_cnt_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  logic [W-1:0] m_osr = '0, m_isr = '0;
  int m_ocnt = 0, m_icnt = 0;
  bit m_pull_pend = 0, m_push_pend = 0;

  always #2.5 clk_i = ~clk_i;

  io_shift_stage u_io_shift_stage (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int dec(logic [4:0] s);
    return (s == 0) ? W : int'(s);
  endfunction

  function automatic logic [W-1:0] emit(logic [W-1:0] r, int n, bit right);
    logic [W-1:0] b = '0;
    for (int i = 0; i < n; i++) b[i] = right ? r[i] : r[W-n+i];
    return b;
  endfunction

  function automatic logic [W-1:0] drain(logic [W-1:0] r, int n, bit right);
    logic [W-1:0] o = '0;
    for (int i = 0; i < W; i++)
      if (right) o[i] = (i + n < W) ? r[i+n] : 1'b0;
      else       o[i] = (i >= n) ? r[i-n] : 1'b0;
    return o;
  endfunction

  function automatic logic [W-1:0] fill(logic [W-1:0] r, logic [W-1:0] d, int n, bit right);
    logic [W-1:0] o = '0;
    for (int i = 0; i < W; i++)
      if (right) o[i] = (i < W - n) ? r[i+n] : d[i-(W-n)];
      else       o[i] = (i < n) ? d[i] : r[i-n];
    return o;
  endfunction

  task automatic step(bit pl, bit tv, logic [W-1:0] td, bit ot, logic [4:0] os, bit od,
                      bit it, logic [4:0] is, logic [W-1:0] idt, bit id, bit ps, bit rr);
    bit preq, pop, oacc, sreq, xfer, iacc;
    int on, inn;
    logic [W-1:0] exp_bits;
    @(negedge clk_i);
    pull_i = pl; txq_valid_i = tv; txq_data_i = td; out_i = ot; out_sel_i = os;
    osr_dir_i = od; in_i = it; in_sel_i = is; in_data_i = idt; isr_dir_i = id;
    push_i = ps; rxq_ready_i = rr;
    preq = pl | m_pull_pend; pop = preq & tv; oacc = ot & ~preq;
    sreq = ps | m_push_pend; xfer = sreq & rr; iacc = it & ~sreq;
    on = dec(os); inn = dec(is);
    #1;
    chk("R2 txq_ready", 64'(txq_ready_o), 64'(pop));
    chk("R11 rxq_valid", 64'(rxq_valid_o), 64'(sreq));
    if (sreq) chk("R11/R8/R9 rxq_data", 64'(rxq_data_o), 64'(m_isr));
    exp_bits = emit(m_osr, on, od);
    if (pop) begin m_osr = td; m_ocnt = 0; end
    else if (oacc) begin
      m_osr = drain(m_osr, on, od);
      m_ocnt = (m_ocnt + on > W) ? W : m_ocnt + on;
    end
    m_pull_pend = preq & ~tv;
    if (xfer) begin m_isr = '0; m_icnt = 0; end
    else if (iacc) begin
      m_isr = fill(m_isr, idt, inn, id);
      m_icnt = (m_icnt + inn > W) ? W : m_icnt + inn;
    end
    m_push_pend = sreq & ~rr;
    @(posedge clk_i); #1;
    chk(ot && preq ? "R13 out_valid" : "R5 out_valid", 64'(out_valid_o), 64'(oacc));
    if (oacc) chk(on == W ? "R4 out_bits" : (od ? "R5 out_bits" : "R6 out_bits"),
                  64'(out_bits_o), 64'(exp_bits));
    chk("R7 osr_cnt", 64'(osr_cnt_o), 64'(m_ocnt));
    chk(it && sreq ? "R13 isr_cnt" : "R10 isr_cnt", 64'(isr_cnt_o), 64'(m_icnt));
    chk("R3 pull_busy", 64'(pull_busy_o), 64'(m_pull_pend));
    chk("R12 push_busy", 64'(push_busy_o), 64'(m_push_pend));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #7;
    chk("R1 osr_cnt", 64'(osr_cnt_o), 0);
    chk("R1 isr_cnt", 64'(isr_cnt_o), 0);
    chk("R1 pull_busy", 64'(pull_busy_o), 0);
    chk("R1 push_busy", 64'(push_busy_o), 0);
    chk("R1 out_valid", 64'(out_valid_o), 0);
    chk("R1 rxq_valid", 64'(rxq_valid_o), 0);
    chk("R1 txq_ready", 64'(txq_ready_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // directed: right out, then full-word select and saturation
    step(1,1,32'hA5A5_1234, 0,0,1, 0,0,0,1, 0,0);
    step(0,0,0, 1,5'd4,1, 0,0,0,1, 0,0);
    step(0,0,0, 1,5'd0,1, 0,0,0,1, 0,0);
    // left out
    step(1,1,32'hF000_000F, 0,0,0, 0,0,0,1, 0,0);
    step(0,0,0, 1,5'd4,0, 0,0,0,1, 0,0);
    step(0,0,0, 1,5'd0,0, 0,0,0,1, 0,0);
    // pull stall, out ignored meanwhile
    step(1,0,0, 0,0,1, 0,0,0,1, 0,0);
    step(0,0,0, 1,5'd3,1, 0,0,0,1, 0,0);
    step(0,1,32'h1357_9BDF, 0,0,1, 0,0,0,1, 0,0);
    step(0,0,0, 1,5'd8,1, 0,0,0,1, 0,0);
    // right in then push
    step(0,0,0, 0,0,1, 1,5'd8,32'hFFFF_FFAB,1, 0,0);
    step(0,0,0, 0,0,1, 0,0,0,1, 1,1);
    // left in, push stall, in ignored, then complete
    step(0,0,0, 0,0,1, 1,5'd8,32'hCD,0, 0,0);
    step(0,0,0, 0,0,1, 1,5'd8,32'hEF,0, 0,0);
    step(0,0,0, 0,0,1, 0,0,0,0, 1,0);
    step(0,0,0, 0,0,1, 1,5'd4,32'h5,0, 0,0);
    step(0,0,0, 0,0,1, 0,0,0,0, 0,1);
    // saturation on input side
    step(0,0,0, 0,0,1, 1,5'd0,32'h8765_4321,1, 0,0);
    step(0,0,0, 0,0,1, 1,5'd9,32'h1FF,1, 0,0);
    step(0,0,0, 0,0,1, 0,0,0,1, 1,1);

    // constrained random
    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 6) == 0, $urandom % 2, $urandom, ($urandom % 2) == 0,
           5'($urandom), 1'($urandom), ($urandom % 2) == 0, 5'($urandom),
           $urandom, 1'($urandom), ($urandom % 5) == 0, ($urandom % 3) != 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule